// File: doc/BRIEF.md
# Pending Bit Update Register Controller

This block is an AXI4-Lite register slave that lets software push a 32-bit pending-interrupt word into the interrupt logic. It holds two registers. The first is a value register that software fills byte by byte. The second is a control register whose bit 0 works as a self-clearing update trigger.

Setting the trigger takes a snapshot of the value register. The block then raises a request toward the interrupt logic, with the snapshot on a data bus beside it. It holds both until the interrupt logic returns a one-cycle acknowledge. Bit 0 stays set for the whole transfer, so software can poll it and learn when the update has been taken. Further triggers are ignored while bit 0 is set.

Reads return after a fixed latency, which is a parameter with a default of three cycles. Accesses outside the two registers complete with an error response.

Top module: `pend_update_ctrl`

## Requirements
- R1: After reset, bvalid, rvalid and pnd_req are low, pnd_data is zero, and both registers read as zero.
- R2: The value register sits at byte offset 0x00 and can be read and written. Write strobe bit i enables data bits 8i+7 down to 8i, and bytes whose strobe is clear keep their old contents.
- R3: The control register sits at byte offset 0x04, and its bit 0 is the update bit. A write there with wstrb[0]=1 and wdata[0]=1, while bit 0 is clear, sets bit 0. In the same cycle as the write response appears, it raises pnd_req.
- R4: pnd_data carries the value register contents as they were when the trigger was accepted. pnd_data and pnd_req stay unchanged until pnd_ack is seen high.
- R5: In the cycle after pnd_ack is sampled high with pnd_req high, pnd_req is low and bit 0 of the control register reads 0.
- R6: While bit 0 is set, a trigger write has no effect and starts no second request. A write of 0 to bit 0 does not clear it.
- R7: rvalid rises exactly RD_LAT cycles (3 by default) after the cycle in which the read address is accepted. rdata and rresp then stay stable until rready. arready is low while a read is outstanding.
- R8: A write to offset 0x00 or 0x04 is answered with bresp OKAY (2'b00). A write to any other address is answered with SLVERR (2'b10) and changes no register. The response is held until bready.
- R9: A read of offset 0x04 returns the update bit in bit 0 and zeros above it. A read of any unmapped address returns zero data with rresp SLVERR (2'b10). Mapped reads return OKAY.
- R10: pnd_ack while pnd_req is low has no effect.
- R11: A value-register write during a transfer updates the register but does not change pnd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| pnd_req | output | 1 | Pending update request to the interrupt logic |
| pnd_data | output | 32 | Pending word snapshot carried with the request |
| pnd_ack | input | 1 | One-cycle acknowledge from the interrupt logic |

## Verification
The assertions assume that the interrupt logic only acknowledges a request that is present. They also assume that AXI masters obey the valid/ready rules, keeping an address or data beat steady until it is accepted. The bench drives inputs on falling edges and holds each valid high across exactly one rising edge with ready high. It raises pnd_ack for a single cycle. It pulses pnd_ack once with no request outstanding, on purpose, to show that nothing changes. Response readiness is withheld for several cycles on some reads, to exercise the hold rule.

// File: rtl/pend_upd_pkg.sv
package pend_upd_pkg;
  localparam int PW = 32;
  localparam int SW = PW / 8;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CTRL  = 2'd2
  } reg_sel_e;

  // Byte-lane merge of a write into a held word.
  function automatic logic [PW-1:0] merge_bytes(input logic [PW-1:0] old_w,
                                                input logic [PW-1:0] new_w,
                                                input logic [SW-1:0] strb);
    logic [PW-1:0] r;
    for (int i = 0; i < SW; i++) begin
      r[i*8 +: 8] = strb[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [1:0] resp_of(input logic hit);
    return hit ? RESP_OKAY : RESP_SLVERR;
  endfunction
endpackage

// File: rtl/pend_wr_chan.sv
module pend_wr_chan
  import pend_upd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [PW-1:0]     wdata,
  input  logic [SW-1:0]     wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output logic              fire_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PW-1:0]     data_o,
  output logic [SW-1:0]     strb_o,
  input  logic              hit_i
);
  logic              aw_full, w_full, bvalid_q;
  logic [ADDR_W-1:0] aw_q;
  logic [PW-1:0]     wd_q;
  logic [SW-1:0]     ws_q;
  logic [1:0]        bresp_q;

  assign awready = !aw_full;
  assign wready  = !w_full;
  // A write executes once both halves are captured and the previous response has left.
  assign fire_o  = aw_full && w_full && !bvalid_q;
  assign addr_o  = aw_q;
  assign data_o  = wd_q;
  assign strb_o  = ws_q;
  assign bvalid  = bvalid_q;
  assign bresp   = bresp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full  <= 1'b0;
      w_full   <= 1'b0;
      aw_q     <= '0;
      wd_q     <= '0;
      ws_q     <= '0;
      bvalid_q <= 1'b0;
      bresp_q  <= RESP_OKAY;
    end else begin
      if (awvalid && awready) begin
        aw_full <= 1'b1;
        aw_q    <= awaddr;
      end else if (fire_o) begin
        aw_full <= 1'b0;
      end
      if (wvalid && wready) begin
        w_full <= 1'b1;
        wd_q   <= wdata;
        ws_q   <= wstrb;
      end else if (fire_o) begin
        w_full <= 1'b0;
      end
      if (fire_o) begin
        bvalid_q <= 1'b1;
        bresp_q  <= resp_of(hit_i);
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pend_rd_chan.sv
module pend_rd_chan
  import pend_upd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [PW-1:0]     rdata,
  output logic [1:0]        rresp,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [PW-1:0]     rd_data_i,
  input  logic              rd_hit_i,
  output logic              ar_hs_o
);
  localparam int STAGES = (RD_LAT < 2) ? 1 : RD_LAT - 1;

  logic [STAGES-1:0] stage_q;
  logic              rvalid_q;
  logic [PW-1:0]     data_q;
  logic [1:0]        resp_q;

  assign arready   = !(|stage_q) && !rvalid_q;
  assign ar_hs_o   = arvalid && arready;
  assign rd_addr_o = araddr;
  assign rvalid    = rvalid_q;
  assign rdata     = rvalid_q ? data_q : '0;
  assign rresp     = resp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= ar_hs_o;
  end

  // Delay line sets the fixed read latency.
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      data_q   <= '0;
      resp_q   <= RESP_OKAY;
    end else begin
      if (ar_hs_o) begin
        data_q <= rd_hit_i ? rd_data_i : '0;
        resp_q <= resp_of(rd_hit_i);
      end
      if (stage_q[STAGES-1])         rvalid_q <= 1'b1;
      else if (rvalid_q && rready)   rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pend_regs.sv
module pend_regs
  import pend_upd_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] VALUE_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PW-1:0]     wr_data,
  input  logic [SW-1:0]     wr_strb,
  output logic              wr_hit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PW-1:0]     rd_data,
  output logic              rd_hit,
  output logic              trig_accept,
  output logic              pnd_req,
  output logic [PW-1:0]     pnd_data,
  input  logic              pnd_ack
);
  function automatic reg_sel_e sel_of(input logic [ADDR_W-1:0] a);
    if (a == VALUE_OFS)     return SEL_VALUE;
    else if (a == CTRL_OFS) return SEL_CTRL;
    else                    return SEL_NONE;
  endfunction

  reg_sel_e      wsel, rsel;
  logic [PW-1:0] value_q, snap_q;
  logic          busy_q;

  assign wsel   = sel_of(wr_addr);
  assign rsel   = sel_of(rd_addr);
  assign wr_hit = (wsel != SEL_NONE);
  assign rd_hit = (rsel != SEL_NONE);

  assign trig_accept = wr_fire && (wsel == SEL_CTRL) && wr_strb[0] && wr_data[0] && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      snap_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (wr_fire && wsel == SEL_VALUE) value_q <= merge_bytes(value_q, wr_data, wr_strb);
      if (trig_accept) begin
        busy_q <= 1'b1;
        snap_q <= value_q;
      end else if (busy_q && pnd_ack) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (rsel)
      SEL_VALUE: rd_data = value_q;
      SEL_CTRL:  rd_data = {{(PW-1){1'b0}}, busy_q};
      default:   rd_data = '0;
    endcase
  end

  assign pnd_req  = busy_q;
  assign pnd_data = snap_q;
endmodule

// File: rtl/pend_update_ctrl.sv
module pend_update_ctrl
  import pend_upd_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                RD_LAT    = 3,
  parameter logic [ADDR_W-1:0] VALUE_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              pnd_req,
  output logic [31:0]       pnd_data,
  input  logic              pnd_ack
);
  // Named internal events, visible to the bound checker.
  logic              wr_fire, wr_hit, rd_hit, ar_hs, trig_accept;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     wr_data, rd_data;
  logic [SW-1:0]     wr_strb;

  pend_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .fire_o(wr_fire), .addr_o(wr_addr), .data_o(wr_data), .strb_o(wr_strb),
    .hit_i(wr_hit)
  );

  pend_rd_chan #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_hit_i(rd_hit), .ar_hs_o(ar_hs)
  );

  pend_regs #(.ADDR_W(ADDR_W), .VALUE_OFS(VALUE_OFS), .CTRL_OFS(CTRL_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .wr_hit(wr_hit), .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit),
    .trig_accept(trig_accept), .pnd_req(pnd_req), .pnd_data(pnd_data),
    .pnd_ack(pnd_ack)
  );
endmodule

// File: rtl/pend_update_ctrl_chk.sv
module pend_update_ctrl_chk #(
  parameter int RD_LAT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        s_bvalid,
  input logic        s_bready,
  input logic [1:0]  s_bresp,
  input logic        s_arready,
  input logic        s_rvalid,
  input logic        s_rready,
  input logic [31:0] s_rdata,
  input logic [1:0]  s_rresp,
  input logic        pnd_req,
  input logic [31:0] pnd_data,
  input logic        pnd_ack,
  input logic        wr_fire,
  input logic        wr_hit,
  input logic        ar_hs,
  input logic        trig_accept
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          lat_cnt <= '0;
    else if (ar_hs)                      lat_cnt <= 16'd1;
    else if (lat_cnt != 0 && !s_rvalid)  lat_cnt <= lat_cnt + 16'd1;
    else if (s_rvalid && s_rready)       lat_cnt <= '0;
  end

  // R3
  trig_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_accept |=> pnd_req && s_bvalid);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pnd_req && !pnd_ack |=> pnd_req && $stable(pnd_data));
  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pnd_req && pnd_ack |=> !pnd_req);
  // R10
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pnd_req && !trig_accept |=> !pnd_req);
  // R7
  rlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_rvalid) |-> lat_cnt == 16'(RD_LAT));
  // R7
  rhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));
  // R7
  ar_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
  // R8
  bhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
  // R8
  bresp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && wr_hit |=> s_bvalid && s_bresp == 2'b00);
endmodule

bind pend_update_ctrl pend_update_ctrl_chk #(.RD_LAT(RD_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_arready(s_arready), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .s_rdata(s_rdata), .s_rresp(s_rresp),
  .pnd_req(pnd_req), .pnd_data(pnd_data), .pnd_ack(pnd_ack),
  .wr_fire(wr_fire), .wr_hit(wr_hit), .ar_hs(ar_hs), .trig_accept(trig_accept)
);

// File: tb/pend_update_ctrl_test.sv
module pend_update_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0, ack = 0;
  logic [7:0]  awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic        awready, wready, bvalid, arready, rvalid, req;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata, pdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pend_update_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .pnd_req(req), .pnd_data(pdata), .pnd_ack(ack)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic [1:0]  resp;
  } vec_t;

  // R2 R8 R9 register access vectors
  localparam vec_t VEC [12] = '{
    '{1'b0, 8'h00, 32'hA5A5_0F0F, 4'hF, 32'h0,         2'd0},
    '{1'b1, 8'h00, 32'h0,         4'h0, 32'hA5A5_0F0F, 2'd0},
    '{1'b0, 8'h00, 32'h1122_3344, 4'h5, 32'h0,         2'd0},
    '{1'b1, 8'h00, 32'h0,         4'h0, 32'hA522_0F44, 2'd0},
    '{1'b0, 8'h00, 32'hFFFF_FFFF, 4'h8, 32'h0,         2'd0},
    '{1'b1, 8'h00, 32'h0,         4'h0, 32'hFF22_0F44, 2'd0},
    '{1'b0, 8'h08, 32'hDEAD_BEEF, 4'hF, 32'h0,         2'd2},
    '{1'b1, 8'h08, 32'h0,         4'h0, 32'h0,         2'd2},
    '{1'b1, 8'h00, 32'h0,         4'h0, 32'hFF22_0F44, 2'd0},
    '{1'b1, 8'h04, 32'h0,         4'h0, 32'h0,         2'd0},
    '{1'b0, 8'h04, 32'h0,         4'hF, 32'h0,         2'd0},
    '{1'b1, 8'h04, 32'h0,         4'h0, 32'h0,         2'd0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          output logic [1:0] resp, output logic req_at_b);
    @(negedge clk);
    awvalid = 1; awaddr = a; wvalid = 1; wdata = d; wstrb = s;
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    while (!bvalid) @(negedge clk);
    resp = bresp; req_at_b = req;
    bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic do_read(input logic [7:0] a, input int hold,
                         output logic [31:0] d, output logic [1:0] resp);
    int lat;
    @(negedge clk);
    arvalid = 1; araddr = a;
    @(posedge clk);
    @(negedge clk);
    arvalid = 0; lat = 1;
    while (!rvalid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 read latency", 32'(lat), 32'd3);
    d = rdata; resp = rresp;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R7 rvalid held", {31'b0, rvalid}, 32'd1);
      chk("R7 rdata held", rdata, d);
      chk("R7 arready low", {31'b0, arready}, 32'd0);
    end
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected under 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  r;
    logic        rb;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 bvalid", {31'b0, bvalid}, 32'd0);
    chk("R1 rvalid", {31'b0, rvalid}, 32'd0);
    chk("R1 pnd_req", {31'b0, req}, 32'd0);
    chk("R1 pnd_data", pdata, 32'd0);
    rst_n = 1;
    do_read(8'h00, 0, d, r); chk("R1 value reg", d, 32'd0);
    do_read(8'h04, 0, d, r); chk("R1 ctrl reg", d, 32'd0);

    // Vector walk: R2 byte strobes, R8 write responses, R9 read responses
    foreach (VEC[i]) begin
      if (VEC[i].rd) begin
        do_read(VEC[i].addr, (i == 3) ? 3 : 0, d, r);
        chk("R2/R9 rdata", d, VEC[i].exp);
        chk("R9 rresp", {30'b0, r}, {30'b0, VEC[i].resp});
      end else begin
        do_write(VEC[i].addr, VEC[i].data, VEC[i].strb, r, rb);
        chk("R8 bresp", {30'b0, r}, {30'b0, VEC[i].resp});
      end
    end
    chk("R3 no trigger from zero write", {31'b0, req}, 32'd0);

    // R3 trigger
    do_write(8'h04, 32'h1, 4'h1, r, rb);
    chk("R3 req with bvalid", {31'b0, rb}, 32'd1);
    chk("R4 snapshot", pdata, 32'hFF22_0F44);
    do_read(8'h04, 0, d, r); chk("R3 ctrl bit set", d, 32'd1);

    // R11 value write during transfer
    do_write(8'h00, 32'h1234_5678, 4'hF, r, rb);
    do_read(8'h00, 2, d, r); chk("R11 value updated", d, 32'h1234_5678);
    chk("R11 pnd_data kept", pdata, 32'hFF22_0F44);

    // R6 retrigger and clear attempts ignored
    do_write(8'h04, 32'h1, 4'h1, r, rb);
    do_write(8'h04, 32'h0, 4'hF, r, rb);
    do_read(8'h04, 0, d, r); chk("R6 ctrl still set", d, 32'd1);
    chk("R6 req held", {31'b0, req}, 32'd1);
    chk("R4 data held", pdata, 32'hFF22_0F44);

    // R5 acknowledge clears
    pulse_ack();
    chk("R5 req dropped", {31'b0, req}, 32'd0);
    do_read(8'h04, 0, d, r); chk("R5 ctrl cleared", d, 32'd0);

    // R10 stray acknowledge
    pulse_ack();
    repeat (2) @(negedge clk);
    chk("R10 req stays low", {31'b0, req}, 32'd0);
    do_read(8'h04, 0, d, r); chk("R10 ctrl stays clear", d, 32'd0);

    // R3 R4 second trigger uses new value; strobe 0 clear ignores it
    do_write(8'h04, 32'h1, 4'h2, r, rb);
    chk("R3 strobe0 clear no trigger", {31'b0, rb}, 32'd0);
    do_write(8'h04, 32'h1, 4'hF, r, rb);
    chk("R3 second trigger", {31'b0, rb}, 32'd1);
    chk("R4 new snapshot", pdata, 32'h1234_5678);
    pulse_ack();
    chk("R5 second clear", {31'b0, req}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule